// File: doc/BRIEF.md
# Reservation Station Issue Lane

This block is one issue lane of an out-of-order integer core. It parks up to eight dispatched instructions until their source operands are available and then issues them to the lane's two execution units: an arithmetic unit and an address-generation unit. A single instruction can request either operation or both. When it requests both, the two halves issue independently and the slot is released only once neither half is still pending.

Every waiting source watches every result-tag broadcast bus in the core, not only those of its own lane. Buses are of two kinds, chosen per bus by a mask parameter:

- **Late buses** present tag and data in the same cycle, and the data is captured directly.
- **Early buses** carry arithmetic results. Their tag arrives one cycle before the matching data. A consumer wakes on the tag and issues in the next cycle, taking the operand straight from the data bus as it arrives.

Among several ready candidates for the same unit, the oldest wins, with age taken from the reorder-buffer tag. A flush discards every waiting entry at once.

Top module: `rs_issue_lane`

## Requirements
- R1: The lane holds up to 8 entries, and `laneFull` is high exactly when all 8 are occupied. It is low after reset.
- R2: An arithmetic instruction dispatched with both sources marked ready issues on the arithmetic port in the next cycle, carrying its tag and both operand values. At most one instruction is accepted per cycle.
- R3: The arithmetic port needs both sources ready. The address port needs only source B, and it drives source B as the base and the dispatched immediate alongside. Each port issues at most one entry per cycle, and both ports may issue in the same cycle.
- R4: A tag match on an early bus in cycle t makes the source ready in cycle t+1. If the entry issues in t+1, the operand is the value on that bus's data lines in t+1, and that value replaces whatever operand value was stored before.
- R5: A tag match on a late bus in cycle t captures that bus's data in the same cycle, and the entry can issue from cycle t+1.
- R6: An entry needing both operations may issue its address half first. It stays occupied until its arithmetic half has also issued.
- R7: A flush empties the lane at the next edge. A dispatch presented in the same cycle is dropped, and flushed entries never issue later.
- R8: When several entries are ready for the same port, the oldest issues first. Age comes from the reorder-buffer tag, whose top bit is a wrap flag and whose lower bits are a sequence number. With equal wrap flags the smaller sequence number is older. With differing wrap flags the larger sequence number is older.
- R9: A source that is not ready at dispatch is also compared against the broadcasts of its dispatch cycle. Such a match behaves as in R4 or R5, according to the kind of bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| dispValid | input | 1 | Dispatch strobe |
| dispRob | input | TAG_W | Reorder-buffer tag of the new instruction |
| dispNeedAlu | input | 1 | Instruction needs the arithmetic unit |
| dispNeedAgu | input | 1 | Instruction needs the address unit |
| dispOp | input | OP_W | Arithmetic operation code |
| dispSrcATag | input | TAG_W | Producer tag of source A |
| dispSrcARdy | input | 1 | Source A value already known |
| dispSrcAVal | input | DATA_W | Source A value when ready |
| dispSrcBTag | input | TAG_W | Producer tag of source B |
| dispSrcBRdy | input | 1 | Source B value already known |
| dispSrcBVal | input | DATA_W | Source B value when ready |
| dispImm | input | DATA_W | Address displacement |
| bcValid | input | NUM_BUS | Per-bus tag broadcast valid |
| bcTag | input | NUM_BUS*TAG_W | Broadcast tags, bus k in slice k |
| resData | input | NUM_BUS*DATA_W | Result data, bus k in slice k |
| laneFull | output | 1 | All entries occupied |
| aluIssue | output | 1 | Arithmetic issue valid |
| aluRob | output | TAG_W | Tag of the issued arithmetic entry |
| aluOp | output | OP_W | Operation code |
| aluOpA | output | DATA_W | Operand A |
| aluOpB | output | DATA_W | Operand B |
| aguIssue | output | 1 | Address issue valid |
| aguRob | output | TAG_W | Tag of the issued address entry |
| aguBase | output | DATA_W | Base operand (source B) |
| aguImm | output | DATA_W | Displacement |

## Verification
The bench builds the lane with four broadcast buses: buses 0 and 1 are early, and buses 2 and 3 are late. With this mix, the bypass path and the direct-capture path can each be reached both from a stored entry and from a same-cycle dispatch. A 7-bit tag makes the wrap flag reachable with small tag values, so the age ordering is exercised with entries on both sides of a wrap. The flush case is run from a completely full lane, followed by a broadcast of the tag the flushed entries were waiting on.

// File: rtl/rsl_pkg.sv
package rsl_pkg;
  parameter int unsigned RS_SLOTS = 8;
  localparam int unsigned SLOT_W = $clog2(RS_SLOTS);

  typedef logic [RS_SLOTS-1:0] slotVec_t;

  // strobes from control to datapath
  typedef struct packed {
    slotVec_t alloc;
    slotVec_t aluGrant;
    slotVec_t aguGrant;
  } laneStrobe_t;
endpackage

// File: rtl/rsl_ctrl.sv
module rsl_ctrl
  import rsl_pkg::*;
#(
  parameter int unsigned TAG_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              dispValid,
  input  logic [TAG_W-1:0]  dispRob,
  input  logic              dispNeedAlu,
  input  logic              dispNeedAgu,
  input  slotVec_t          aluOpsOk,
  input  slotVec_t          aguOpsOk,
  output laneStrobe_t       strobe,
  output logic              laneFull,
  output logic              aluIssue,
  output logic              aguIssue,
  output logic [TAG_W-1:0]  aluRob,
  output logic [TAG_W-1:0]  aguRob
);
  localparam int unsigned SEQ_W = TAG_W - 1;

  slotVec_t validQ, needAluQ, needAguQ;
  logic [TAG_W-1:0] robQ [RS_SLOTS];
  logic [RS_SLOTS*TAG_W-1:0] robFlat;
  slotVec_t freeVec, allocVec, aluCand, aguCand, aluGrant, aguGrant;
  logic dispTake;

  function automatic logic isOlder(input logic [TAG_W-1:0] a, input logic [TAG_W-1:0] b);
    if (a[TAG_W-1] == b[TAG_W-1]) return a[SEQ_W-1:0] < b[SEQ_W-1:0];
    else                          return a[SEQ_W-1:0] > b[SEQ_W-1:0];
  endfunction

  function automatic slotVec_t pickOldest(input slotVec_t cand,
                                          input logic [RS_SLOTS*TAG_W-1:0] robs);
    slotVec_t win;
    for (int i = 0; i < RS_SLOTS; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < RS_SLOTS; j++) begin
        if (j != i && cand[j]) begin
          if (isOlder(robs[j*TAG_W +: TAG_W], robs[i*TAG_W +: TAG_W])) win[i] = 1'b0;
          else if (robs[j*TAG_W +: TAG_W] == robs[i*TAG_W +: TAG_W] && j < i) win[i] = 1'b0;
        end
      end
    end
    return win;
  endfunction

  generate
    for (genvar g = 0; g < RS_SLOTS; g++) begin : g_flat
      assign robFlat[g*TAG_W +: TAG_W] = robQ[g];
    end
  endgenerate

  assign freeVec  = ~validQ;
  assign dispTake = dispValid && !flush && (dispNeedAlu || dispNeedAgu);
  assign allocVec = dispTake ? (freeVec & (~freeVec + 1'b1)) : '0;
  assign aluCand  = validQ & needAluQ & aluOpsOk;
  assign aguCand  = validQ & needAguQ & aguOpsOk;
  assign aluGrant = pickOldest(aluCand, robFlat);
  assign aguGrant = pickOldest(aguCand, robFlat);

  assign strobe.alloc    = allocVec;
  assign strobe.aluGrant = aluGrant;
  assign strobe.aguGrant = aguGrant;

  assign laneFull = &validQ;
  assign aluIssue = |aluGrant;
  assign aguIssue = |aguGrant;

  always_comb begin
    aluRob = '0;
    aguRob = '0;
    for (int i = 0; i < RS_SLOTS; i++) begin
      if (aluGrant[i]) aluRob = aluRob | robQ[i];
      if (aguGrant[i]) aguRob = aguRob | robQ[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= '0;
      needAluQ <= '0;
      needAguQ <= '0;
      for (int i = 0; i < RS_SLOTS; i++) robQ[i] <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < RS_SLOTS; i++) begin
        if (allocVec[i]) begin
          validQ[i]   <= 1'b1;
          needAluQ[i] <= dispNeedAlu;
          needAguQ[i] <= dispNeedAgu;
          robQ[i]     <= dispRob;
        end else if (validQ[i]) begin
          needAluQ[i] <= needAluQ[i] & ~aluGrant[i];
          needAguQ[i] <= needAguQ[i] & ~aguGrant[i];
          if (!(needAluQ[i] & ~aluGrant[i]) && !(needAguQ[i] & ~aguGrant[i]))
            validQ[i] <= 1'b0;
        end
      end
    end
  end

  // R7: flush leaves no entry behind
  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validQ == '0));

  // R3: grants only to occupied entries still needing that unit
  p_grant_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((aluGrant & ~(validQ & needAluQ)) == '0) && ((aguGrant & ~(validQ & needAguQ)) == '0));

  // R3: one issue per port per cycle
  p_grant_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(aluGrant) && $onehot0(aguGrant));

  generate
    for (genvar g = 0; g < RS_SLOTS; g++) begin : g_chk
      // R6: address half alone does not release a dual entry
      p_keep_until_both_r6: assert property (@(posedge clk) disable iff (!rstN)
        (validQ[g] && needAluQ[g] && needAguQ[g] && aguGrant[g] && !aluGrant[g] && !flush)
        |=> (validQ[g] && needAluQ[g] && !needAguQ[g]));
    end
  endgenerate
endmodule

// File: rtl/rsl_data.sv
module rsl_data
  import rsl_pkg::*;
#(
  parameter int unsigned NUM_BUS    = 4,
  parameter int unsigned TAG_W      = 7,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OP_W       = 4,
  parameter logic [NUM_BUS-1:0] EARLY_MASK = 4'b0011
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  laneStrobe_t                strobe,
  input  logic [OP_W-1:0]            dispOp,
  input  logic [TAG_W-1:0]           dispSrcATag,
  input  logic                       dispSrcARdy,
  input  logic [DATA_W-1:0]          dispSrcAVal,
  input  logic [TAG_W-1:0]           dispSrcBTag,
  input  logic                       dispSrcBRdy,
  input  logic [DATA_W-1:0]          dispSrcBVal,
  input  logic [DATA_W-1:0]          dispImm,
  input  logic [NUM_BUS-1:0]         bcValid,
  input  logic [NUM_BUS*TAG_W-1:0]   bcTag,
  input  logic [NUM_BUS*DATA_W-1:0]  resData,
  output slotVec_t                   aluOpsOk,
  output slotVec_t                   aguOpsOk,
  output logic [OP_W-1:0]            aluOp,
  output logic [DATA_W-1:0]          aluOpA,
  output logic [DATA_W-1:0]          aluOpB,
  output logic [DATA_W-1:0]          aguBase,
  output logic [DATA_W-1:0]          aguImm
);
  localparam int unsigned BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
  localparam int unsigned NSRC  = 2;

  typedef struct packed {
    logic              early;
    logic              late;
    logic [BUS_W-1:0]  bus;
    logic [DATA_W-1:0] data;
  } snoop_t;

  function automatic snoop_t snoop(input logic [TAG_W-1:0] t,
                                   input logic [NUM_BUS-1:0] v,
                                   input logic [NUM_BUS*TAG_W-1:0] tags,
                                   input logic [NUM_BUS*DATA_W-1:0] datas);
    snoop_t r;
    r = '0;
    for (int k = 0; k < NUM_BUS; k++) begin
      if (v[k] && tags[k*TAG_W +: TAG_W] == t) begin
        if (EARLY_MASK[k]) begin
          r.early = 1'b1;
          r.bus   = BUS_W'(k);
        end else begin
          r.late = 1'b1;
          r.data = datas[k*DATA_W +: DATA_W];
        end
      end
    end
    return r;
  endfunction

  logic [DATA_W-1:0] dataArr [NUM_BUS];
  logic [TAG_W-1:0]  dTag [NSRC];
  logic              dRdy [NSRC];
  logic [DATA_W-1:0] dVal [NSRC];

  logic [TAG_W-1:0]  srcTagQ  [RS_SLOTS][NSRC];
  logic              srcRdyQ  [RS_SLOTS][NSRC];
  logic              srcPendQ [RS_SLOTS][NSRC];
  logic [BUS_W-1:0]  srcBusQ  [RS_SLOTS][NSRC];
  logic [DATA_W-1:0] srcValQ  [RS_SLOTS][NSRC];
  logic [DATA_W-1:0] effVal   [RS_SLOTS][NSRC];
  logic              srcOk    [RS_SLOTS][NSRC];
  logic [DATA_W-1:0] immQ [RS_SLOTS];
  logic [OP_W-1:0]   opQ  [RS_SLOTS];

  generate
    for (genvar k = 0; k < NUM_BUS; k++) begin : g_bus
      assign dataArr[k] = resData[k*DATA_W +: DATA_W];
    end
  endgenerate

  assign dTag[0] = dispSrcATag;
  assign dTag[1] = dispSrcBTag;
  assign dRdy[0] = dispSrcARdy;
  assign dRdy[1] = dispSrcBRdy;
  assign dVal[0] = dispSrcAVal;
  assign dVal[1] = dispSrcBVal;

  snoop_t dHit [NSRC];
  generate
    for (genvar s = 0; s < NSRC; s++) begin : g_dsnoop
      assign dHit[s] = snoop(dTag[s], bcValid, bcTag, resData);
    end
  endgenerate

  generate
    for (genvar i = 0; i < RS_SLOTS; i++) begin : g_slot
      for (genvar s = 0; s < NSRC; s++) begin : g_src
        snoop_t hit;
        assign hit          = snoop(srcTagQ[i][s], bcValid, bcTag, resData);
        assign srcOk[i][s]  = srcRdyQ[i][s] | srcPendQ[i][s];
        assign effVal[i][s] = srcPendQ[i][s] ? dataArr[srcBusQ[i][s]] : srcValQ[i][s];

        always_ff @(posedge clk) begin
          if (!rstN) begin
            srcTagQ[i][s]  <= '0;
            srcRdyQ[i][s]  <= 1'b0;
            srcPendQ[i][s] <= 1'b0;
            srcBusQ[i][s]  <= '0;
            srcValQ[i][s]  <= '0;
          end else if (strobe.alloc[i]) begin
            srcTagQ[i][s] <= dTag[s];
            srcBusQ[i][s] <= dHit[s].bus;
            if (dRdy[s]) begin
              srcRdyQ[i][s]  <= 1'b1;
              srcPendQ[i][s] <= 1'b0;
              srcValQ[i][s]  <= dVal[s];
            end else if (dHit[s].late) begin
              srcRdyQ[i][s]  <= 1'b1;
              srcPendQ[i][s] <= 1'b0;
              srcValQ[i][s]  <= dHit[s].data;
            end else begin
              srcRdyQ[i][s]  <= 1'b0;
              srcPendQ[i][s] <= dHit[s].early;
              srcValQ[i][s]  <= dVal[s];
            end
          end else if (srcPendQ[i][s]) begin
            srcRdyQ[i][s]  <= 1'b1;
            srcPendQ[i][s] <= 1'b0;
            srcValQ[i][s]  <= effVal[i][s];
          end else if (!srcRdyQ[i][s]) begin
            if (hit.late) begin
              srcRdyQ[i][s] <= 1'b1;
              srcValQ[i][s] <= hit.data;
            end else if (hit.early) begin
              srcPendQ[i][s] <= 1'b1;
              srcBusQ[i][s]  <= hit.bus;
            end
          end
        end

        // R4: an early tag hit makes the source usable next cycle
        p_early_wake_r4: assert property (@(posedge clk) disable iff (!rstN)
          (!strobe.alloc[i] && !srcRdyQ[i][s] && !srcPendQ[i][s] && hit.early && !hit.late)
          |=> (srcOk[i][s] && srcBusQ[i][s] == $past(hit.bus)));

        // R4: bypassed data replaces the stored operand
        p_bypass_capture_r4: assert property (@(posedge clk) disable iff (!rstN)
          (srcPendQ[i][s] && !strobe.alloc[i])
          |=> (srcRdyQ[i][s] && srcValQ[i][s] == $past(effVal[i][s])));

        // R5: late hit captures its data at once
        p_late_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
          (!strobe.alloc[i] && !srcRdyQ[i][s] && !srcPendQ[i][s] && hit.late)
          |=> (srcRdyQ[i][s] && srcValQ[i][s] == $past(hit.data)));
      end

      assign aluOpsOk[i] = srcOk[i][0] & srcOk[i][1];
      assign aguOpsOk[i] = srcOk[i][1];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          immQ[i] <= '0;
          opQ[i]  <= '0;
        end else if (strobe.alloc[i]) begin
          immQ[i] <= dispImm;
          opQ[i]  <= dispOp;
        end
      end
    end
  endgenerate

  always_comb begin
    aluOp   = '0;
    aluOpA  = '0;
    aluOpB  = '0;
    aguBase = '0;
    aguImm  = '0;
    for (int i = 0; i < RS_SLOTS; i++) begin
      if (strobe.aluGrant[i]) begin
        aluOp  = aluOp  | opQ[i];
        aluOpA = aluOpA | effVal[i][0];
        aluOpB = aluOpB | effVal[i][1];
      end
      if (strobe.aguGrant[i]) begin
        aguBase = aguBase | effVal[i][1];
        aguImm  = aguImm  | immQ[i];
      end
    end
  end
endmodule

// File: rtl/rs_issue_lane.sv
module rs_issue_lane
  import rsl_pkg::*;
#(
  parameter int unsigned NUM_BUS    = 4,
  parameter int unsigned TAG_W      = 7,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OP_W       = 4,
  parameter logic [NUM_BUS-1:0] EARLY_MASK = 4'b0011
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      flush,
  input  logic                      dispValid,
  input  logic [TAG_W-1:0]          dispRob,
  input  logic                      dispNeedAlu,
  input  logic                      dispNeedAgu,
  input  logic [OP_W-1:0]           dispOp,
  input  logic [TAG_W-1:0]          dispSrcATag,
  input  logic                      dispSrcARdy,
  input  logic [DATA_W-1:0]         dispSrcAVal,
  input  logic [TAG_W-1:0]          dispSrcBTag,
  input  logic                      dispSrcBRdy,
  input  logic [DATA_W-1:0]         dispSrcBVal,
  input  logic [DATA_W-1:0]         dispImm,
  input  logic [NUM_BUS-1:0]        bcValid,
  input  logic [NUM_BUS*TAG_W-1:0]  bcTag,
  input  logic [NUM_BUS*DATA_W-1:0] resData,
  output logic                      laneFull,
  output logic                      aluIssue,
  output logic [TAG_W-1:0]          aluRob,
  output logic [OP_W-1:0]           aluOp,
  output logic [DATA_W-1:0]         aluOpA,
  output logic [DATA_W-1:0]         aluOpB,
  output logic                      aguIssue,
  output logic [TAG_W-1:0]          aguRob,
  output logic [DATA_W-1:0]         aguBase,
  output logic [DATA_W-1:0]         aguImm
);
  laneStrobe_t strobe;
  slotVec_t    aluOpsOk, aguOpsOk;

  rsl_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .dispValid(dispValid), .dispRob(dispRob),
    .dispNeedAlu(dispNeedAlu), .dispNeedAgu(dispNeedAgu),
    .aluOpsOk(aluOpsOk), .aguOpsOk(aguOpsOk),
    .strobe(strobe), .laneFull(laneFull),
    .aluIssue(aluIssue), .aguIssue(aguIssue),
    .aluRob(aluRob), .aguRob(aguRob)
  );

  rsl_data #(
    .NUM_BUS(NUM_BUS), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .OP_W(OP_W), .EARLY_MASK(EARLY_MASK)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .dispOp(dispOp),
    .dispSrcATag(dispSrcATag), .dispSrcARdy(dispSrcARdy), .dispSrcAVal(dispSrcAVal),
    .dispSrcBTag(dispSrcBTag), .dispSrcBRdy(dispSrcBRdy), .dispSrcBVal(dispSrcBVal),
    .dispImm(dispImm),
    .bcValid(bcValid), .bcTag(bcTag), .resData(resData),
    .aluOpsOk(aluOpsOk), .aguOpsOk(aguOpsOk),
    .aluOp(aluOp), .aluOpA(aluOpA), .aluOpB(aluOpB),
    .aguBase(aguBase), .aguImm(aguImm)
  );
endmodule

// File: tb/sim_rs_issue_lane.sv
`timescale 1ns/1ps
module sim_rs_issue_lane;
  localparam int NB = 4;
  localparam int TW = 7;
  localparam int DW = 32;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic dispValid = 1'b0;
  logic [TW-1:0] dispRob = '0;
  logic dispNeedAlu = 1'b0, dispNeedAgu = 1'b0;
  logic [OW-1:0] dispOp = '0;
  logic [TW-1:0] dispSrcATag = '0, dispSrcBTag = '0;
  logic dispSrcARdy = 1'b0, dispSrcBRdy = 1'b0;
  logic [DW-1:0] dispSrcAVal = '0, dispSrcBVal = '0, dispImm = '0;
  logic [NB-1:0] bcValid = '0;
  logic [NB*TW-1:0] bcTag = '0;
  logic [NB*DW-1:0] resData = '0;
  logic laneFull, aluIssue, aguIssue;
  logic [TW-1:0] aluRob, aguRob;
  logic [OW-1:0] aluOp;
  logic [DW-1:0] aluOpA, aluOpB, aguBase, aguImm;

  always #10 clk = ~clk;

  rs_issue_lane #(.NUM_BUS(NB), .TAG_W(TW), .DATA_W(DW), .OP_W(OW), .EARLY_MASK(4'b0011)) u0 (
    .clk(clk), .rstN(rstN), .flush(flush), .dispValid(dispValid), .dispRob(dispRob),
    .dispNeedAlu(dispNeedAlu), .dispNeedAgu(dispNeedAgu), .dispOp(dispOp),
    .dispSrcATag(dispSrcATag), .dispSrcARdy(dispSrcARdy), .dispSrcAVal(dispSrcAVal),
    .dispSrcBTag(dispSrcBTag), .dispSrcBRdy(dispSrcBRdy), .dispSrcBVal(dispSrcBVal),
    .dispImm(dispImm), .bcValid(bcValid), .bcTag(bcTag), .resData(resData),
    .laneFull(laneFull), .aluIssue(aluIssue), .aluRob(aluRob), .aluOp(aluOp),
    .aluOpA(aluOpA), .aluOpB(aluOpB), .aguIssue(aguIssue), .aguRob(aguRob),
    .aguBase(aguBase), .aguImm(aguImm)
  );

  typedef struct {
    int cyc;
    logic [TW-1:0] rob;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    string req;
  } exp_t;

  exp_t aluQ[$];
  exp_t aguQ[$];
  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // monitor: compare issues against the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rstN && !done) begin
      if (aluIssue) begin
        if (aluQ.size() == 0) check(1'b0, "R7", "unexpected alu issue rob", 64'(aluRob), 64'h0);
        else begin
          e = aluQ.pop_front();
          check(aluRob == e.rob, e.req, "alu rob", 64'(aluRob), 64'(e.rob));
          check(aluOpA == e.a && aluOpB == e.b, e.req, "alu operands",
                {aluOpA, aluOpB}, {e.a, e.b});
          check(cyc == e.cyc, e.req, "alu issue cycle", 64'(cyc), 64'(e.cyc));
        end
      end else if (aluQ.size() > 0 && aluQ[0].cyc <= cyc) begin
        e = aluQ.pop_front();
        check(1'b0, e.req, "missing alu issue rob", 64'h0, 64'(e.rob));
      end
      if (aguIssue) begin
        if (aguQ.size() == 0) check(1'b0, "R7", "unexpected agu issue rob", 64'(aguRob), 64'h0);
        else begin
          e = aguQ.pop_front();
          check(aguRob == e.rob, e.req, "agu rob", 64'(aguRob), 64'(e.rob));
          check(aguBase == e.a && aguImm == e.b, e.req, "agu base/imm",
                {aguBase, aguImm}, {e.a, e.b});
          check(cyc == e.cyc, e.req, "agu issue cycle", 64'(cyc), 64'(e.cyc));
        end
      end else if (aguQ.size() > 0 && aguQ[0].cyc <= cyc) begin
        e = aguQ.pop_front();
        check(1'b0, e.req, "missing agu issue rob", 64'h0, 64'(e.rob));
      end
    end
  end

  task automatic pushAlu(input int c, input logic [TW-1:0] rob, input logic [DW-1:0] a,
                         input logic [DW-1:0] b, input string req);
    exp_t e;
    e.cyc = c; e.rob = rob; e.a = a; e.b = b; e.req = req;
    aluQ.push_back(e);
  endtask

  task automatic pushAgu(input int c, input logic [TW-1:0] rob, input logic [DW-1:0] base,
                         input logic [DW-1:0] imm, input string req);
    exp_t e;
    e.cyc = c; e.rob = rob; e.a = base; e.b = imm; e.req = req;
    aguQ.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    dispValid = 1'b0;
    bcValid = '0;
    flush = 1'b0;
  endtask

  task automatic dispatch(input logic [TW-1:0] rob, input bit nAlu, input bit nAgu,
                          input logic [TW-1:0] aTag, input bit aRdy, input logic [DW-1:0] aVal,
                          input logic [TW-1:0] bTag, input bit bRdy, input logic [DW-1:0] bVal,
                          input logic [DW-1:0] imm);
    dispValid = 1'b1; dispRob = rob; dispNeedAlu = nAlu; dispNeedAgu = nAgu;
    dispOp = 4'h3;
    dispSrcATag = aTag; dispSrcARdy = aRdy; dispSrcAVal = aVal;
    dispSrcBTag = bTag; dispSrcBRdy = bRdy; dispSrcBVal = bVal;
    dispImm = imm;
  endtask

  task automatic bcast(input int k, input logic [TW-1:0] tag, input logic [DW-1:0] data);
    bcValid[k] = 1'b1;
    bcTag[k*TW +: TW] = tag;
    resData[k*DW +: DW] = data;
  endtask

  task automatic setData(input int k, input logic [DW-1:0] data);
    resData[k*DW +: DW] = data;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    // R1: empty after reset
    check(laneFull == 1'b0, "R1", "laneFull after reset", 64'(laneFull), 64'h0);
    check(!aluIssue && !aguIssue, "R1", "no issue after reset", {aluIssue, aguIssue}, 64'h0);

    // R2: ready arithmetic instruction issues next cycle
    dispatch(7'd5, 1, 0, 7'd0, 1, 32'd10, 7'd0, 1, 32'd20, 32'd0);
    pushAlu(cyc + 1, 7'd5, 32'd10, 32'd20, "R2");
    tick(); tick();

    // R3: address-only instruction drives source B and immediate
    dispatch(7'd6, 0, 1, 7'd0, 1, 32'd0, 7'd0, 1, 32'h100, 32'd8);
    pushAgu(cyc + 1, 7'd6, 32'h100, 32'd8, "R3");
    tick(); tick();

    // R6 + R4: dual entry, address half first, arithmetic waits on early bus 0
    dispatch(7'd7, 1, 1, 7'd40, 0, 32'hDEAD, 7'd0, 1, 32'h200, 32'd4);
    pushAgu(cyc + 1, 7'd7, 32'h200, 32'd4, "R6");
    tick(); tick();
    bcast(0, 7'd40, 32'h1111);
    tick();
    setData(0, 32'h55);
    pushAlu(cyc, 7'd7, 32'h55, 32'h200, "R4");
    tick();
    setData(0, 32'h99);
    tick();

    // R5: late bus 2 carries data with its tag
    dispatch(7'd8, 1, 0, 7'd41, 0, 32'h0, 7'd0, 1, 32'd3, 32'd0);
    tick();
    bcast(2, 7'd41, 32'h77);
    pushAlu(cyc + 1, 7'd8, 32'h77, 32'd3, "R5");
    tick(); tick();

    // R9: same-cycle broadcast at dispatch, late bus 3 then early bus 1
    dispatch(7'd9, 1, 0, 7'd42, 0, 32'h0, 7'd0, 1, 32'd1, 32'd0);
    bcast(3, 7'd42, 32'h88);
    pushAlu(cyc + 1, 7'd9, 32'h88, 32'd1, "R9");
    tick(); tick();
    dispatch(7'd10, 1, 0, 7'd43, 0, 32'hBAD, 7'd0, 1, 32'd2, 32'd0);
    bcast(1, 7'd43, 32'h0);
    tick();
    setData(1, 32'hAB);
    pushAlu(cyc, 7'd10, 32'hAB, 32'd2, "R9");
    tick(); tick();

    // R8: oldest first across a wrap (bit 6 = wrap flag, bits 5:0 = sequence)
    dispatch(7'h41, 1, 0, 7'd50, 0, 32'h0, 7'd0, 1, 32'd1, 32'd0);
    tick();
    dispatch(7'h3E, 1, 0, 7'd50, 0, 32'h0, 7'd0, 1, 32'd2, 32'd0);
    tick();
    dispatch(7'h3C, 1, 0, 7'd50, 0, 32'h0, 7'd0, 1, 32'd3, 32'd0);
    tick();
    bcast(2, 7'd50, 32'h5);
    pushAlu(cyc + 1, 7'h3C, 32'h5, 32'd3, "R8");
    pushAlu(cyc + 2, 7'h3E, 32'h5, 32'd2, "R8");
    pushAlu(cyc + 3, 7'h41, 32'h5, 32'd1, "R8");
    repeat (5) tick();

    // R1: fill the lane
    for (int n = 0; n < 8; n++) begin
      if (n == 7) check(laneFull == 1'b0, "R1", "laneFull with 7 entries", 64'(laneFull), 64'h0);
      dispatch(7'(8'h10 + n), 1, 0, 7'd60, 0, 32'h0, 7'd0, 1, 32'd1, 32'd0);
      tick();
    end
    check(laneFull == 1'b1, "R1", "laneFull with 8 entries", 64'(laneFull), 64'h1);

    // R7: flush with a simultaneous dispatch
    flush = 1'b1;
    dispatch(7'h20, 1, 0, 7'd0, 1, 32'd1, 7'd0, 1, 32'd1, 32'd0);
    tick();
    check(laneFull == 1'b0, "R7", "laneFull after flush", 64'(laneFull), 64'h0);
    check(aluIssue == 1'b0, "R7", "dropped dispatch issued", 64'(aluIssue), 64'h0);
    bcast(2, 7'd60, 32'h1);
    tick();
    check(aluIssue == 1'b0, "R7", "flushed entry woke", 64'(aluIssue), 64'h0);
    tick(); tick();

    // R3: both ports in the same cycle, then the slot is free again
    dispatch(7'h22, 1, 1, 7'd0, 1, 32'd4, 7'd0, 1, 32'd6, 32'd1);
    pushAlu(cyc + 1, 7'h22, 32'd4, 32'd6, "R3");
    pushAgu(cyc + 1, 7'h22, 32'd6, 32'd1, "R3");
    tick(); tick(); tick();
    check(laneFull == 1'b0, "R6", "lane drained", 64'(laneFull), 64'h0);

    repeat (3) tick();
    check(aluQ.size() == 0 && aguQ.size() == 0, "R2", "pending expectations",
          64'(aluQ.size() + aguQ.size()), 64'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule